// File: doc/BRIEF.md
# Dual-Mode Host Bus Channel Decoder

This block sits between an asynchronous host processor bus and the register banks of a four-channel serial controller. It brings the host pins into the system clock domain and decodes each host bus cycle into exactly one register request. Each request is a single-cycle read or write pulse that carries a channel index, a 3-bit register address and, for writes, the data byte. For reads, it also returns the register byte to the host and drives the data bus output enable.

A static strap input selects one of two bus styles. With the strap high, the block uses separate active-low read and write strobes and one active-low select per channel. With the strap low, select 0 is the only chip select and the write strobe pin is a direction line (high for read, low for write). In this style, selects 1 and 2 are channel address bits, while the read strobe and select 3 are don't-care. The bidirectional data bus is split into an input byte, an output byte and an output enable. The pad is expected to combine them.

Top module: `hostbus_front`

## Requirements
- R1: While reset is high and after it is released with idle pins, req_rd, req_wr, sel_err and bus_oe are 0 and bus_dout is 0.
- R2: With mode_split = 1, exactly one cs_n bit low and rd_n pulsed low, one req_rd pulse is produced. Its req_chan is the index of the low cs_n bit and its req_rsel equals addr. The pulse comes three clock edges after the falling edge of rd_n.
- R3: With mode_split = 1, exactly one cs_n bit low and wr_n pulsed low, one req_wr pulse is produced after wr_n rises. It carries req_chan equal to the index of the low cs_n bit, req_rsel = addr and req_wdata = bus_din.
- R4: With mode_split = 0 and wr_n high, a low pulse on cs_n[0] produces one req_rd pulse with req_chan = {cs_n[2], cs_n[1]} (00 to 11 give channels 0 to 3) and req_rsel = addr.
- R5: With mode_split = 0 and wr_n low, a low pulse on cs_n[0] produces one req_wr pulse after cs_n[0] rises. It carries req_chan = {cs_n[2], cs_n[1]}, req_rsel = addr and req_wdata = bus_din.
- R6: With mode_split = 1, a strobe falling while two or more cs_n bits are low produces no request, and sel_err goes high for exactly one cycle.
- R7: With mode_split = 1, a strobe pulse while no cs_n bit is low produces no request and no sel_err.
- R8: With mode_split = 0, rd_n and cs_n[3] have no effect on requests or on channel selection.
- R9: bus_oe is high only during a read that issued a request. It goes high with req_rd and falls after the read strobe or select is released. It stays low for writes and for rejected cycles.
- R10: bus_dout takes the rf_rdata value presented while req_rd is high, one cycle after req_rd, and holds it until the next read request.
- R11: req_rd and req_wr each last one cycle, and a single bus cycle never produces more than one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_split | input | 1 | Static strap: 1 = separate strobes with per-channel selects, 0 = single select with direction line |
| rd_n | input | 1 | Read strobe, active low (don't-care when mode_split = 0) |
| wr_n | input | 1 | Write strobe (mode_split = 1) or direction line, high = read (mode_split = 0) |
| cs_n | input | 4 | Per-channel selects (mode_split = 1). With mode_split = 0: bit 0 is the chip select, bits 2:1 are the channel number, bit 3 is unused |
| addr | input | 3 | Register address within the channel |
| bus_din | input | 8 | Data byte from the host |
| bus_dout | output | 8 | Read data byte to the host |
| bus_oe | output | 1 | Output enable for the data bus pad |
| rf_rdata | input | 8 | Register byte returned for req_chan/req_rsel |
| req_rd | output | 1 | One-cycle register read request |
| req_wr | output | 1 | One-cycle register write request |
| req_chan | output | 2 | Channel index of the request |
| req_rsel | output | 3 | Register address of the request |
| req_wdata | output | 8 | Write data of the request |
| sel_err | output | 1 | One-cycle pulse when several channel selects are active in one cycle |

## Verification
The bench sweeps every channel and every register address for both reads and writes in both bus styles. The data byte is varied with the address, so a swapped channel, address or data field shows up as a wrong value. In split mode it also tries every cs_n pattern with two or more bits low, to tell rejected cycles apart from valid ones, and the all-idle select pattern, to show that an unselected strobe does nothing. In single-select mode, rd_n is toggled during every cycle and cs_n[3] is varied, so a decode that still uses those pins gives wrong counts or channels. Each read is also checked for output enable timing and for the returned byte, and each write is checked for the absence of output enable.

// File: rtl/hbf_pkg.sv
package hbf_pkg;

    localparam int NCH    = 4;
    localparam int AW     = 3;
    localparam int DW     = 8;
    localparam int CW     = $clog2(NCH);
    localparam int SYNC_W = 2 + NCH + AW + DW;

    // idle pattern of the synchronised pin vector {rd_n, wr_n, cs_n, addr, din}
    localparam logic [SYNC_W-1:0] SYNC_IDLE = {2'b11, {NCH{1'b1}}, {(AW+DW){1'b0}}};

    typedef struct packed {
        logic          rd_act;
        logic          wr_act;
        logic          sel_ok;
        logic          multi;
        logic [CW-1:0] chan;
        logic [AW-1:0] rsel;
        logic [DW-1:0] data;
    } bus_view_t;

    function automatic int unsigned low_count(input logic [NCH-1:0] sel_n);
        int unsigned n;
        n = 0;
        for (int i = 0; i < NCH; i++) begin
            if (!sel_n[i]) n++;
        end
        return n;
    endfunction

    function automatic logic [CW-1:0] low_index(input logic [NCH-1:0] sel_n);
        logic [CW-1:0] idx;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (!sel_n[i]) idx = CW'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/hbf_sync.sv
module hbf_sync #(
    parameter int                W       = 8,
    parameter logic [W-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/hbf_decode.sv
module hbf_decode
    import hbf_pkg::*;
(
    input  logic                mode_split,
    input  logic [SYNC_W-1:0]   pins,
    output bus_view_t           view
);
    logic          p_rd_n;
    logic          p_wr_n;
    logic [NCH-1:0] p_cs_n;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_data;
    int unsigned   nlow;

    assign {p_rd_n, p_wr_n, p_cs_n, p_addr, p_data} = pins;
    assign nlow = low_count(p_cs_n);

    always_comb begin
        view.rsel = p_addr;
        view.data = p_data;
        if (mode_split) begin
            view.rd_act = !p_rd_n;
            view.wr_act = !p_wr_n;
            view.sel_ok = (nlow == 1);
            view.multi  = (nlow > 1);
            view.chan   = low_index(p_cs_n);
        end else begin
            view.rd_act = !p_cs_n[0] && p_wr_n;
            view.wr_act = !p_cs_n[0] && !p_wr_n;
            view.sel_ok = 1'b1;
            view.multi  = 1'b0;
            view.chan   = p_cs_n[CW:1];
        end
    end
endmodule

// File: rtl/hbf_ctrl.sv
module hbf_ctrl
    import hbf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  bus_view_t     view,
    input  logic [DW-1:0] rf_rdata,
    output logic          req_rd,
    output logic          req_wr,
    output logic [CW-1:0] req_chan,
    output logic [AW-1:0] req_rsel,
    output logic [DW-1:0] req_wdata,
    output logic          sel_err,
    output logic [DW-1:0] bus_dout,
    output logic          bus_oe
);
    logic          rd_act_q;
    logic          wr_act_q;
    logic          wr_pend;
    logic          rd_busy;
    logic [CW-1:0] w_chan;
    logic [AW-1:0] w_rsel;
    logic [DW-1:0] w_data;
    logic          rd_start;
    logic          wr_start;
    logic          wr_end;

    assign rd_start = view.rd_act && !rd_act_q;
    assign wr_start = view.wr_act && !wr_act_q;
    assign wr_end   = !view.wr_act && wr_act_q;
    assign bus_oe   = rd_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_act_q  <= 1'b0;
            wr_act_q  <= 1'b0;
            wr_pend   <= 1'b0;
            rd_busy   <= 1'b0;
            req_rd    <= 1'b0;
            req_wr    <= 1'b0;
            sel_err   <= 1'b0;
            req_chan  <= '0;
            req_rsel  <= '0;
            req_wdata <= '0;
            w_chan    <= '0;
            w_rsel    <= '0;
            w_data    <= '0;
            bus_dout  <= '0;
        end else begin
            req_rd   <= 1'b0;
            req_wr   <= 1'b0;
            sel_err  <= 1'b0;
            rd_act_q <= view.rd_act;
            wr_act_q <= view.wr_act;

            if (rd_start) begin
                if (view.multi) begin
                    sel_err <= 1'b1;
                end else if (view.sel_ok) begin
                    req_rd   <= 1'b1;
                    req_chan <= view.chan;
                    req_rsel <= view.rsel;
                    rd_busy  <= 1'b1;
                end
            end else if (!view.rd_act) begin
                rd_busy <= 1'b0;
            end

            if (wr_start) begin
                if (view.multi) sel_err <= 1'b1;
                wr_pend <= view.sel_ok && !view.multi;
            end

            if (view.wr_act) begin
                w_chan <= view.chan;
                w_rsel <= view.rsel;
                w_data <= view.data;
            end

            if (wr_end && wr_pend) begin
                req_wr    <= 1'b1;
                req_chan  <= w_chan;
                req_rsel  <= w_rsel;
                req_wdata <= w_data;
                wr_pend   <= 1'b0;
            end

            if (req_rd) bus_dout <= rf_rdata;
        end
    end

    assert_single_req_R11: assert property (@(posedge clk) disable iff (rst)
        !(req_rd && req_wr));
    assert_rd_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        req_rd |=> !req_rd);
    assert_wr_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        req_wr |=> !req_wr);
    assert_err_no_req_R6: assert property (@(posedge clk) disable iff (rst)
        sel_err |-> (!req_rd && !req_wr));
    assert_err_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        sel_err |=> !sel_err);
    assert_oe_with_req_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> req_rd);
    assert_dout_load_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(bus_dout) |-> $past(req_rd));
endmodule

// File: rtl/hostbus_front.sv
module hostbus_front
    import hbf_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           mode_split,
    input  logic           rd_n,
    input  logic           wr_n,
    input  logic [NCH-1:0] cs_n,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  bus_din,
    output logic [DW-1:0]  bus_dout,
    output logic           bus_oe,
    input  logic [DW-1:0]  rf_rdata,
    output logic           req_rd,
    output logic           req_wr,
    output logic [CW-1:0]  req_chan,
    output logic [AW-1:0]  req_rsel,
    output logic [DW-1:0]  req_wdata,
    output logic           sel_err
);
    logic [SYNC_W-1:0] pins_s;
    bus_view_t         view;

    hbf_sync #(.W(SYNC_W), .RST_VAL(SYNC_IDLE)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({rd_n, wr_n, cs_n, addr, bus_din}),
        .q_sync  (pins_s)
    );

    hbf_decode u_decode (
        .mode_split (mode_split),
        .pins       (pins_s),
        .view       (view)
    );

    hbf_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .view      (view),
        .rf_rdata  (rf_rdata),
        .req_rd    (req_rd),
        .req_wr    (req_wr),
        .req_chan  (req_chan),
        .req_rsel  (req_rsel),
        .req_wdata (req_wdata),
        .sel_err   (sel_err),
        .bus_dout  (bus_dout),
        .bus_oe    (bus_oe)
    );
endmodule

// File: tb/test_hostbus_front.sv
`timescale 1ns/1ps
module test_hostbus_front;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_split = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [3:0] cs_n = 4'hF;
    logic [2:0] addr = '0;
    logic [7:0] bus_din = '0;
    logic [7:0] bus_dout;
    logic       bus_oe;
    logic [7:0] rf_rdata;
    logic       req_rd, req_wr, sel_err;
    logic [1:0] req_chan;
    logic [2:0] req_rsel;
    logic [7:0] req_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] rf_model(input logic [1:0] ch, input logic [2:0] rs);
        return {ch, rs, ~ch[0], rs[0] ^ ch[1], 1'b1};
    endfunction

    assign rf_rdata = rf_model(req_chan, req_rsel);

    hostbus_front i_hostbus_front (
        .clk(clk), .rst(rst), .mode_split(mode_split), .rd_n(rd_n), .wr_n(wr_n),
        .cs_n(cs_n), .addr(addr), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .rf_rdata(rf_rdata), .req_rd(req_rd), .req_wr(req_wr),
        .req_chan(req_chan), .req_rsel(req_rsel), .req_wdata(req_wdata),
        .sel_err(sel_err)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    int n_rd, n_wr, n_err, oe_bad;
    logic [1:0] c_ch;
    logic [2:0] c_rs;
    logic [7:0] c_wd;

    task automatic sample_cycle(input bit oe_allowed);
        @(negedge clk);
        if (req_rd) begin n_rd++; c_ch = req_chan; c_rs = req_rsel; end
        if (req_wr) begin n_wr++; c_ch = req_chan; c_rs = req_rsel; c_wd = req_wdata; end
        if (sel_err) n_err++;
        if (bus_oe && !oe_allowed) oe_bad++;
    endtask

    // kind: 0 = ignored, 1 = accepted, 2 = select error
    task automatic xact(input bit m, input bit is_rd, input logic [3:0] csv,
                        input logic [2:0] a, input logic [7:0] d, input int kind,
                        input logic [1:0] ech, input string tag);
        bit ok_rd;
        ok_rd = is_rd && (kind == 1);
        n_rd = 0; n_wr = 0; n_err = 0; oe_bad = 0;
        @(negedge clk);
        mode_split = m; addr = a; bus_din = d;
        if (m) begin
            cs_n = csv;
        end else begin
            cs_n = csv | 4'b0001;
            wr_n = is_rd;
        end
        @(negedge clk);
        if (m) begin
            if (is_rd) rd_n = 1'b0; else wr_n = 1'b0;
        end else begin
            cs_n[0] = 1'b0;
            rd_n = 1'b0;
        end
        for (int i = 0; i < 8; i++) begin
            sample_cycle(ok_rd);
            if (!m && i == 3) rd_n = 1'b1;
        end
        if (ok_rd) begin
            chk(bus_oe == 1'b1, {tag, " R9 oe during read"}, bus_oe, 1);
            chk(bus_dout == rf_model(ech, a), {tag, " R10 read data"}, bus_dout, rf_model(ech, a));
        end
        if (m) begin rd_n = 1'b1; wr_n = 1'b1; end
        else cs_n[0] = 1'b1;
        for (int i = 0; i < 8; i++) sample_cycle(ok_rd && i < 3);
        rd_n = 1'b1; wr_n = 1'b1; cs_n = 4'hF;
        for (int i = 0; i < 4; i++) sample_cycle(1'b0);
        if (ok_rd)
            chk(bus_dout == rf_model(ech, a), {tag, " R10 data held"}, bus_dout, rf_model(ech, a));
        chk(bus_oe == 1'b0, {tag, " R9 oe released"}, bus_oe, 0);
        chk(oe_bad == 0, {tag, " R9 oe outside valid read"}, oe_bad, 0);
        chk(n_rd == ((kind == 1 && is_rd) ? 1 : 0), {tag, " R11 read count"}, n_rd, (kind == 1 && is_rd) ? 1 : 0);
        chk(n_wr == ((kind == 1 && !is_rd) ? 1 : 0), {tag, " R11 write count"}, n_wr, (kind == 1 && !is_rd) ? 1 : 0);
        chk(n_err == ((kind == 2) ? 1 : 0), {tag, " R6 error count"}, n_err, (kind == 2) ? 1 : 0);
        if (kind == 1) begin
            chk(c_ch == ech, {tag, " channel"}, c_ch, ech);
            chk(c_rs == a, {tag, " register"}, c_rs, a);
            if (!is_rd) chk(c_wd == d, {tag, " write data"}, c_wd, d);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!req_rd && !req_wr && !sel_err && !bus_oe && bus_dout == 0, "R1 in reset", {req_rd, req_wr, sel_err, bus_oe}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(!req_rd && !req_wr && !sel_err && !bus_oe && bus_dout == 0, "R1 after reset", {req_rd, req_wr, sel_err, bus_oe}, 0);

        // split style: every channel and register (R2 read, R3 write)
        for (int ch = 0; ch < 4; ch++) begin
            for (int a = 0; a < 8; a++) begin
                xact(1'b1, 1'b1, ~(4'b1 << ch), 3'(a), 8'(a * 37 + ch * 11), 1, 2'(ch), "R2 split read");
                xact(1'b1, 1'b0, ~(4'b1 << ch), 3'(a), 8'(a * 29 + ch * 67 + 5), 1, 2'(ch), "R3 split write");
            end
        end

        // single-select style (R4 read, R5 write), cs_n[3] and rd_n varied (R8)
        for (int ch = 0; ch < 4; ch++) begin
            for (int a = 0; a < 8; a++) begin
                logic [3:0] v;
                v = {a[0] ^ ch[1], 2'(ch), 1'b1};
                xact(1'b0, 1'b1, v, 3'(a), 8'(a * 13 + ch), 1, 2'(ch), "R4 R8 single read");
                xact(1'b0, 1'b0, v, 3'(a), 8'(255 - a * 31 - ch * 3), 1, 2'(ch), "R5 R8 single write");
            end
        end

        // several selects low (R6)
        for (int p = 0; p < 16; p++) begin
            if ($countones(~4'(p)) >= 2) begin
                xact(1'b1, 1'b1, 4'(p), 3'(p), 8'(p), 2, 2'd0, "R6 multi read");
                xact(1'b1, 1'b0, 4'(p), 3'(p), 8'(p), 2, 2'd0, "R6 multi write");
            end
        end

        // no select (R7)
        xact(1'b1, 1'b1, 4'hF, 3'd5, 8'h3C, 0, 2'd0, "R7 no select read");
        xact(1'b1, 1'b0, 4'hF, 3'd6, 8'hC3, 0, 2'd0, "R7 no select write");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule